// File: doc/BRIEF.md
# UART Receive Flow-Control RTS Generator

This block holds received bytes in a small first-in first-out store and drives an active-low request-to-send pin from either software or the store's fill count. Bytes enter on a valid/ready stream from a serial receiver and leave on a second valid/ready stream toward the consumer. A small register port sets the pin's source, a software request bit and a level marker.

The write stream uses `in_ready` as back-pressure: a byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low exactly when the store is full. The receiver cannot stall, so a byte offered while `in_ready` is low is lost, and that loss raises a sticky overrun flag. On the read stream, `out_valid` is high whenever the store holds a byte, and `out_data` shows the oldest byte. A byte is removed on an edge where `out_valid` and `out_ready` are both high.

In software mode the pin follows the software request bit. In FIFO mode the pin follows the fill count in one of two ways, chosen by a trigger-select bit. With trigger-select 0 the pin is asserted only while the count equals the level marker. With trigger-select 1 it is asserted only while exactly one slot is free. The pin is decoded combinationally from registered state, so it changes in the same cycle as the count or the register that caused the change.

Top module: `uart_rx_rts_gen`

## Requirements
- R1: After reset the store is empty, `fill_count` is 0, `overrun` is 0, `rts_n` is 1 (deasserted), and both registers read back as 0.
- R2: `in_ready` is 1 exactly when fewer than DEPTH bytes are held. `out_valid` is 1 exactly when at least one byte is held. Bytes leave in the order they were accepted.
- R3: `fill_count` rises by one on an accepted write and falls by one on an accepted read. It is unchanged when both happen on the same edge, and it never exceeds DEPTH.
- R4: A write offered while full is dropped and sets `overrun`, which then stays 1 until reset.
- R5: With control bit 7 (FIFO mode) at 0, `rts_n` is the inverse of control bit 0 (software request). Store traffic has no effect on the pin in this mode.
- R6: With bit 7 at 1 and control bit 8 (trigger-select) at 0, `rts_n` is 0 exactly while `fill_count` equals the level marker.
- R7: With bit 7 at 1 and bit 8 at 1, `rts_n` is 0 exactly while `fill_count` equals DEPTH-1.
- R8: Address 0 is the control register, with bit 0 the software request, bit 7 FIFO mode and bit 8 trigger-select. Every other bit, reserved bit 9 included, reads 0. Address 1 is the level marker: its low ceil(log2(DEPTH+1)) bits are stored, and its upper bits read 0. A register write takes effect on the edge where `reg_we` is high, and `reg_rdata` shows the addressed register combinationally.
- R9: A read request while empty changes nothing: the count stays 0 and no byte is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Received byte offered |
| in_ready | output | 1 | Store can accept a byte |
| in_data | input | DATA_W | Received byte |
| out_valid | output | 1 | Store holds a byte |
| out_ready | input | 1 | Consumer takes the head byte |
| out_data | output | DATA_W | Oldest held byte |
| fill_count | output | ceil(log2(DEPTH+1)) | Number of bytes held |
| overrun | output | 1 | Sticky: a write was dropped while full |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 1 | 0 selects control, 1 selects level marker |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Addressed register contents |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The assertions rely on the stream and register strobes holding defined values at every sampled edge after reset. They do not require `in_valid` to stay high once raised, because a dropped byte is legal behaviour here. The bench drives every input to a known value from time zero and changes inputs only on falling edges. Its random phase picks both register addresses, any write data and any mix of write and read requests. This covers level markers above DEPTH, which must never match, and offers made while the store is full.

// File: rtl/uart_rts_pkg.sv
package uart_rts_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned SW_BIT   = 0;
  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned TRIG_BIT = 8;
  localparam int unsigned RSVD_BIT = 9;

  typedef struct packed {
    logic trig_one_left;
    logic fifo_mode;
    logic sw_req;
  } rts_ctrl_t;

  typedef enum logic [1:0] {
    SRC_SW       = 2'd0,
    SRC_LEVEL    = 2'd1,
    SRC_ONE_LEFT = 2'd2
  } rts_src_e;

  function automatic rts_src_e pick_src(input rts_ctrl_t c);
    if (!c.fifo_mode)        return SRC_SW;
    else if (c.trig_one_left) return SRC_ONE_LEFT;
    else                      return SRC_LEVEL;
  endfunction
endpackage

// File: rtl/uart_rts_fifo.sv
module uart_rts_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  fill,
  output logic              overrun
);
  localparam bit POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CNT_W-1:0]  count;
  logic              full, empty, push, pop;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign in_ready = !full;
  assign out_valid = !empty;
  assign push     = in_valid && !full;
  assign pop      = out_ready && !empty;
  assign out_data = mem[rd_ptr];
  assign fill     = count;

  generate
    if (POW2) begin : g_wrap_natural
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (in_valid && full) overrun <= 1'b1;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count)); // R3
  AST_PUSH_ONLY_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count == $past(count) + 1'b1)); // R3
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun); // R4
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R4
  AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !out_valid && !in_valid) |=> (count == '0)); // R9
endmodule

// File: rtl/uart_rts_regs.sv
module uart_rts_regs
  import uart_rts_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output rts_ctrl_t        ctrl,
  output logic [CNT_W-1:0] level
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      level <= '0;
    end else if (reg_we) begin
      if (!reg_addr) begin
        ctrl.sw_req        <= reg_wdata[SW_BIT];
        ctrl.fifo_mode     <= reg_wdata[MODE_BIT];
        ctrl.trig_one_left <= reg_wdata[TRIG_BIT];
      end else begin
        level <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_addr) begin
      reg_rdata[SW_BIT]   = ctrl.sw_req;
      reg_rdata[MODE_BIT] = ctrl.fifo_mode;
      reg_rdata[TRIG_BIT] = ctrl.trig_one_left;
    end else begin
      reg_rdata = REG_W'(level);
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> (reg_rdata[RSVD_BIT] == 1'b0)); // R8
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr) |=> (ctrl.fifo_mode == $past(reg_wdata[MODE_BIT]))); // R8
endmodule

// File: rtl/uart_rts_detect.sv
module uart_rts_detect
  import uart_rts_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  rts_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] fill,
  input  logic [CNT_W-1:0] level,
  output logic             rts_n
);
  rts_src_e src;
  logic     want;

  always_comb begin
    src = pick_src(ctrl);
    unique case (src)
      SRC_SW:       want = ctrl.sw_req;
      SRC_LEVEL:    want = (fill == level);
      SRC_ONE_LEFT: want = (fill == CNT_W'(DEPTH - 1));
      default:      want = 1'b0;
    endcase
    rts_n = !want;
  end
endmodule

// File: rtl/uart_rx_rts_gen.sv
module uart_rx_rts_gen
  import uart_rts_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  fill_count,
  output logic              overrun,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              rts_n
);
  rts_ctrl_t        ctrl;
  logic [CNT_W-1:0] level;

  uart_rts_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fill(fill_count), .overrun(overrun)
  );

  uart_rts_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctrl(ctrl), .level(level)
  );

  uart_rts_detect #(.DEPTH(DEPTH)) u_detect (
    .ctrl(ctrl), .fill(fill_count), .level(level), .rts_n(rts_n)
  );

  AST_SW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.fifo_mode |-> (rts_n == !ctrl.sw_req)); // R5
  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.fifo_mode && !ctrl.trig_one_left) |-> (!rts_n == (fill_count == level))); // R6
  AST_ONE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.fifo_mode && ctrl.trig_one_left) |-> (!rts_n == (fill_count == CNT_W'(DEPTH - 1)))); // R7
endmodule

// File: tb/sim_uart_rx_rts_gen.sv
module sim_uart_rx_rts_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] in_data = '0;
  logic [15:0] reg_wdata = '0;
  logic in_ready, out_valid, overrun, rts_n;
  logic [7:0] out_data;
  logic [CNT_W-1:0] fill_count;
  logic [15:0] reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  byte unsigned q[$];
  bit m_sw = 0, m_mode = 0, m_trig = 0, m_ovr = 0;
  int m_level = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_rts_gen #(.DATA_W(8), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fill_count(fill_count), .overrun(overrun),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rts_n(rts_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_rdata();
    if (!reg_addr) return (int'(m_sw)) | (int'(m_mode) << 7) | (int'(m_trig) << 8);
    return m_level;
  endfunction

  task automatic compare_all();
    bit want;
    string tag;
    chk("R2", "in_ready", int'(in_ready), int'(q.size() < DEPTH));
    chk("R2", "out_valid", int'(out_valid), int'(q.size() > 0));
    if (q.size() > 0) chk("R2", "out_data", int'(out_data), int'(q[0]));
    chk("R3", "fill_count", int'(fill_count), q.size());
    chk("R4", "overrun", int'(overrun), int'(m_ovr));
    if (!m_mode) begin want = m_sw; tag = "R5"; end
    else if (m_trig) begin want = (q.size() == DEPTH - 1); tag = "R7"; end
    else begin want = (q.size() == m_level); tag = "R6"; end
    chk(tag, "rts_n", int'(rts_n), int'(!want));
    chk("R8", "reg_rdata", int'(reg_rdata), exp_rdata());
  endtask

  task automatic tick(input bit iv, input byte unsigned d, input bit ordy,
                      input bit we, input bit addr, input logic [15:0] wd);
    int sz;
    @(negedge clk);
    in_valid = iv; in_data = d; out_ready = ordy;
    reg_we = we; reg_addr = addr; reg_wdata = wd;
    @(posedge clk);
    sz = q.size();
    if (iv && sz == DEPTH) m_ovr = 1;
    if (ordy && sz > 0) void'(q.pop_front());
    if (iv && sz < DEPTH) q.push_back(d);
    if (we) begin
      if (!addr) begin m_sw = wd[0]; m_mode = wd[7]; m_trig = wd[8]; end
      else m_level = int'(wd) & ((1 << CNT_W) - 1);
    end
    #1;
    compare_all();
  endtask

  task automatic wr_reg(input bit addr, input logic [15:0] wd);
    tick(0, 8'h00, 0, 1, addr, wd);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "rts_n", int'(rts_n), 1);
    chk("R1", "fill_count", int'(fill_count), 0);
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "ctrl read", int'(reg_rdata), 0);
    reg_addr = 1'b1; #1;
    chk("R1", "level read", int'(reg_rdata), 0);

    // R5 software mode; traffic has no effect
    wr_reg(0, 16'h0001);
    for (int i = 0; i < 3; i++) tick(1, 8'(i + 8'hA0), 0, 0, 0, 16'h0);
    wr_reg(0, 16'h0000);
    tick(0, 8'h00, 1, 0, 0, 16'h0);
    // R8 reserved and unused bits read 0
    wr_reg(0, 16'hFE7E);
    wr_reg(1, 16'hFFE5);
    for (int i = 0; i < 2; i++) tick(0, 8'h00, 1, 0, 0, 16'h0);

    // R6 level marker 5, walk count 0..7 and back
    wr_reg(1, 16'd5);
    wr_reg(0, 16'h0080);
    for (int i = 0; i < 7; i++) tick(1, 8'(i + 8'h10), 0, 0, 1, 16'h0);
    for (int i = 0; i < 2; i++) tick(0, 8'h00, 1, 0, 1, 16'h0);
    tick(1, 8'h55, 1, 0, 1, 16'h0);   // R3 count held at 5 on push+pop
    tick(0, 8'h00, 1, 0, 1, 16'h0);

    // R7 one slot left: fill to full, overflow, step back
    wr_reg(0, 16'h0180);
    while (q.size() < DEPTH) tick(1, 8'(q.size() + 8'h30), 0, 0, 0, 16'h0);
    tick(1, 8'hEE, 0, 0, 0, 16'h0);   // R4 dropped write
    tick(1, 8'hEF, 1, 0, 0, 16'h0);   // full: pop only
    tick(1, 8'hF0, 0, 0, 0, 16'h0);
    tick(0, 8'h00, 1, 0, 0, 16'h0);

    // R9 drain then read while empty
    while (q.size() > 0) tick(0, 8'h00, 1, 0, 0, 16'h0);
    for (int i = 0; i < 3; i++) tick(0, 8'h00, 1, 0, 0, 16'h0);

    // Level marker 0 and DEPTH boundaries
    wr_reg(1, 16'd0);
    wr_reg(0, 16'h0080);
    tick(1, 8'h01, 0, 0, 1, 16'h0);
    wr_reg(1, 16'(DEPTH));
    while (q.size() < DEPTH) tick(1, 8'h02, 0, 0, 1, 16'h0);
    tick(0, 8'h00, 1, 0, 1, 16'h0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      bit we = ($urandom_range(0, 15) == 0);
      tick(bit'($urandom_range(0, 1)), 8'($urandom), bit'($urandom_range(0, 1)),
           we, bit'($urandom_range(0, 1)), 16'($urandom));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule